// File: doc/BRIEF.md
# Rename Map Table with Branch Checkpoints

This block holds the speculative register map of a scalar out-of-order core. Each architectural register has an entry with a valid bit and a reorder-buffer tag. A clear valid bit means the committed value sits in the architectural register file. A set bit means the value will come from the reorder-buffer entry named by the tag. Each cycle the rename stage reads two source mappings and may write one destination mapping.

When a branch is renamed, the whole table, including that branch's own destination mapping, is copied into a free checkpoint slot. The slot number is returned so that it can travel with the branch. Slots are allocated in circular order. A mispredict found early restores the live table from a named slot in one cycle. That restore releases the named slot and every slot allocated after it. A mispredict found at retirement instead clears every valid bit at once. A correctly resolved branch gives its slot back through a release port. The retire port clears every entry whose tag matches the retiring instruction, both in the live table and in all stored snapshots.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset every map entry reads invalid, all checkpoint slots are free and the first branch renamed receives slot 0.
- R2: The source outputs show the live entry (valid bit and tag) of the selected register before this cycle's write. A rename with the destination enable set writes valid=1 and the given tag, and this is visible from the next cycle on. With the enable clear, the table is unchanged.
- R3: Accepted branch renames take slots 0,1,2,...,NUM_CKPT-1 and then wrap. Each snapshot holds the table as it stands after that branch's own destination write.
- R4: When a branch is renamed and the slot at the allocation pointer is still busy, the stall output is high in that cycle. That rename is then dropped entirely: no snapshot and no table write.
- R5: A restore makes the live table equal to the named snapshot on the next cycle. It releases the named slot and every later-allocated slot, and the next branch receives the restored slot number.
- R6: A release of a slot makes it free. A branch rename stalls for as long as the slot at the allocation pointer is busy, even if other slots are free.
- R7: A retire clears the valid bit of every live entry and every snapshot entry whose tag equals the retiring tag. Other entries are kept.
- R8: A flush clears every live valid bit, releases all slots and returns the allocation pointer to slot 0. It takes precedence over a restore and a rename in the same cycle.
- R9: A rename requested in the same cycle as a restore is dropped.
- R10: A retire in the same cycle as a restore is applied to the restored contents.
- R11: A retire in the same cycle as a rename is applied first, so the new destination mapping survives even when its tag equals the retiring tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0_idx | input | AREG_W | First source register number |
| src1_idx | input | AREG_W | Second source register number |
| src0_valid | output | 1 | First source is in flight |
| src0_tag | output | TAG_W | First source reorder-buffer tag |
| src1_valid | output | 1 | Second source is in flight |
| src1_tag | output | TAG_W | Second source reorder-buffer tag |
| ren_req | input | 1 | Rename request this cycle |
| ren_is_branch | input | 1 | Renamed instruction is a branch |
| ren_dst_en | input | 1 | Renamed instruction writes a register |
| ren_dst_idx | input | AREG_W | Destination register number |
| ren_dst_tag | input | TAG_W | Destination reorder-buffer tag |
| ckpt_id | output | CK_W | Slot given to a branch renamed this cycle |
| ckpt_stall | output | 1 | Branch rename refused, no free slot at pointer |
| restore_req | input | 1 | Early mispredict recovery request |
| restore_id | input | CK_W | Slot to restore from |
| flush_all | input | 1 | Late mispredict recovery, clear all mappings |
| free_req | input | 1 | Release a slot of a correctly resolved branch |
| free_id | input | CK_W | Slot to release |
| ret_req | input | 1 | Instruction retiring this cycle |
| ret_tag | input | TAG_W | Tag of the retiring instruction |

## Verification
The bench builds the block with 8 architectural registers, 5-bit tags and the default 4 checkpoint slots. With these values it can read back the whole table through the two source ports after every scenario. It also fills every slot with only a few branch renames, which brings the stall, the wrap of the allocation pointer and a restore that spans the wrap within a short run. Same-cycle collisions are driven on purpose: restore with rename, restore with retire, rename with retire of the same tag, and flush with rename.

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt #(
  parameter int NUM_AREG = 32,
  parameter int TAG_W    = 6,
  parameter int NUM_CKPT = 4,
  localparam int AREG_W  = $clog2(NUM_AREG),
  localparam int CK_W    = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AREG_W-1:0] src0_idx,
  input  logic [AREG_W-1:0] src1_idx,
  output logic              src0_valid,
  output logic [TAG_W-1:0]  src0_tag,
  output logic              src1_valid,
  output logic [TAG_W-1:0]  src1_tag,
  input  logic              ren_req,
  input  logic              ren_is_branch,
  input  logic              ren_dst_en,
  input  logic [AREG_W-1:0] ren_dst_idx,
  input  logic [TAG_W-1:0]  ren_dst_tag,
  output logic [CK_W-1:0]   ckpt_id,
  output logic              ckpt_stall,
  input  logic              restore_req,
  input  logic [CK_W-1:0]   restore_id,
  input  logic              flush_all,
  input  logic              free_req,
  input  logic [CK_W-1:0]   free_id,
  input  logic              ret_req,
  input  logic [TAG_W-1:0]  ret_tag
);

  logic [NUM_AREG-1:0] live_v;
  logic [TAG_W-1:0]    live_t [NUM_AREG];
  logic [NUM_AREG-1:0] snap_v [NUM_CKPT];
  logic [TAG_W-1:0]    snap_t [NUM_CKPT][NUM_AREG];
  logic [NUM_CKPT-1:0] busy;
  logic [CK_W-1:0]     alloc_ptr;

  logic [NUM_AREG-1:0] nxt_v;
  logic [TAG_W-1:0]    nxt_t [NUM_AREG];
  logic [NUM_CKPT-1:0] release_mask;
  logic                do_restore, ren_take, take_snap;
  logic [CK_W-1:0]     span;

  assign src0_valid = live_v[src0_idx];
  assign src0_tag   = live_t[src0_idx];
  assign src1_valid = live_v[src1_idx];
  assign src1_tag   = live_t[src1_idx];

  assign ckpt_id    = alloc_ptr;
  assign ckpt_stall = ren_req & ren_is_branch & busy[alloc_ptr];
  assign do_restore = restore_req & ~flush_all;
  assign ren_take   = ren_req & ~restore_req & ~flush_all & ~ckpt_stall;
  assign take_snap  = ren_take & ren_is_branch;
  assign span       = alloc_ptr - restore_id;

  always_comb begin
    for (int i = 0; i < NUM_AREG; i++) begin
      nxt_v[i] = do_restore ? snap_v[restore_id][i] : live_v[i];
      nxt_t[i] = do_restore ? snap_t[restore_id][i] : live_t[i];
      if (ret_req && nxt_t[i] == ret_tag)
        nxt_v[i] = 1'b0;
    end
    if (ren_take && ren_dst_en) begin
      nxt_v[ren_dst_idx] = 1'b1;
      nxt_t[ren_dst_idx] = ren_dst_tag;
    end
    if (flush_all)
      nxt_v = '0;
  end

  always_comb begin
    release_mask = '0;
    if (free_req)
      release_mask[free_id] = 1'b1;
    if (do_restore)
      for (int k = 0; k < NUM_CKPT; k++)
        if (span == '0 || (CK_W'(k) - restore_id) < span)
          release_mask[k] = 1'b1;
    if (flush_all)
      release_mask = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_v    <= '0;
      busy      <= '0;
      alloc_ptr <= '0;
      for (int i = 0; i < NUM_AREG; i++)
        live_t[i] <= '0;
    end else begin
      live_v <= nxt_v;
      live_t <= nxt_t;
      busy   <= (busy & ~release_mask) |
                (take_snap ? (NUM_CKPT'(1) << alloc_ptr) : '0);
      if (flush_all)
        alloc_ptr <= '0;
      else if (do_restore)
        alloc_ptr <= restore_id;
      else if (take_snap)
        alloc_ptr <= alloc_ptr + 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_v[s] <= '0;
        for (int i = 0; i < NUM_AREG; i++)
          snap_t[s][i] <= '0;
      end else if (take_snap && alloc_ptr == CK_W'(s)) begin
        snap_v[s] <= nxt_v;
        snap_t[s] <= nxt_t;
      end else if (ret_req) begin
        for (int i = 0; i < NUM_AREG; i++)
          if (snap_t[s][i] == ret_tag)
            snap_v[s][i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rename_map_ckpt_chk.sv
module rename_map_ckpt_chk #(
  parameter int NUM_AREG = 32,
  parameter int NUM_CKPT = 4,
  localparam int CK_W    = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ren_req,
  input logic                ren_is_branch,
  input logic                restore_req,
  input logic [CK_W-1:0]     restore_id,
  input logic                flush_all,
  input logic                free_req,
  input logic                ret_req,
  input logic                ckpt_stall,
  input logic [NUM_CKPT-1:0] busy,
  input logic [CK_W-1:0]     alloc_ptr,
  input logic [NUM_AREG-1:0] live_v
);

  // R4
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_stall |-> (ren_req && ren_is_branch));

  // R4
  stall_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_stall && !restore_req && !flush_all && !free_req && !ret_req)
      |=> ($stable(live_v) && $stable(busy) && $stable(alloc_ptr)));

  // R3
  alloc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_req && ren_is_branch && !ckpt_stall && !restore_req && !flush_all)
      |=> (busy[$past(alloc_ptr)] && alloc_ptr == $past(alloc_ptr) + 1'b1));

  // R5
  restore_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !flush_all)
      |=> (!busy[$past(restore_id)] && alloc_ptr == $past(restore_id)));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (live_v == '0 && busy == '0 && alloc_ptr == '0));

endmodule

bind rename_map_ckpt rename_map_ckpt_chk #(.NUM_AREG(NUM_AREG), .NUM_CKPT(NUM_CKPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_req(ren_req), .ren_is_branch(ren_is_branch),
  .restore_req(restore_req), .restore_id(restore_id), .flush_all(flush_all),
  .free_req(free_req), .ret_req(ret_req), .ckpt_stall(ckpt_stall),
  .busy(busy), .alloc_ptr(alloc_ptr), .live_v(live_v)
);

// File: tb/rename_map_ckpt_bench.sv
module rename_map_ckpt_bench;
  localparam int NA = 8;
  localparam int TW = 5;
  localparam int NC = 4;
  localparam int AW = 3;
  localparam int CW = 2;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] src0_idx = 0, src1_idx = 0;
  logic src0_valid, src1_valid;
  logic [TW-1:0] src0_tag, src1_tag;
  logic ren_req = 0, ren_is_branch = 0, ren_dst_en = 0;
  logic [AW-1:0] ren_dst_idx = 0;
  logic [TW-1:0] ren_dst_tag = 0;
  logic [CW-1:0] ckpt_id;
  logic ckpt_stall;
  logic restore_req = 0, flush_all = 0, free_req = 0, ret_req = 0;
  logic [CW-1:0] restore_id = 0, free_id = 0;
  logic [TW-1:0] ret_tag = 0;

  int checks = 0, fails = 0;
  logic          ev [NA];
  logic [TW-1:0] et [NA];

  always #4 clk = ~clk;

  rename_map_ckpt #(.NUM_AREG(NA), .TAG_W(TW), .NUM_CKPT(NC)) u_rename_map_ckpt (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_req = 0; ren_is_branch = 0; ren_dst_en = 0;
    restore_req = 0; flush_all = 0; free_req = 0; ret_req = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic ren(bit br, bit de, int d, int t);
    ren_req = 1; ren_is_branch = br; ren_dst_en = de;
    ren_dst_idx = AW'(d); ren_dst_tag = TW'(t);
  endtask

  task automatic set_exp(int r, bit v, int t);
    ev[r] = v; et[r] = TW'(t);
  endtask

  task automatic cmp_table(string req);
    for (int r = 0; r < NA; r++) begin
      src0_idx = AW'(r); src1_idx = AW'(NA - 1 - r);
      #1;
      chk(req, src0_valid, ev[r]);
      if (ev[r]) chk(req, src0_tag, et[r]);
      chk(req, src1_valid, ev[NA-1-r]);
    end
  endtask

  task automatic branch_expect(string req, int id);
    ren(1, 0, 0, 0); #1;
    chk(req, ckpt_stall, 0);
    chk(req, ckpt_id, id);
    cyc();
  endtask

  task automatic t_reset();
    for (int r = 0; r < NA; r++) set_exp(r, 0, 0);
    cmp_table("R1");
    ren(1, 0, 0, 0); #1;
    chk("R1", ckpt_stall, 0);
    chk("R1", ckpt_id, 0);
    idle();
  endtask

  task automatic t_rename_basic();
    ren(0, 1, 3, 5); cyc(); set_exp(3, 1, 5);
    ren(0, 1, 5, 9); cyc(); set_exp(5, 1, 9);
    ren(0, 0, 6, 22); cyc();
    cmp_table("R2");
    src0_idx = 3; ren(0, 1, 3, 17); #1;
    chk("R2", src0_tag, 5);
    ren_dst_tag = 5; ren_req = 0;
  endtask

  task automatic t_checkpoints();
    ren(1, 1, 1, 10); #1; chk("R3", ckpt_id, 0); cyc(); set_exp(1, 1, 10);
    ren(1, 0, 0, 0);  #1; chk("R3", ckpt_id, 1); cyc();
    ren(0, 1, 2, 11); cyc(); set_exp(2, 1, 11);
    ren(1, 1, 4, 12); #1; chk("R3", ckpt_id, 2); cyc(); set_exp(4, 1, 12);
    ren(1, 0, 0, 0);  #1; chk("R3", ckpt_id, 3); cyc();
    ren(1, 1, 6, 20); #1; chk("R4", ckpt_stall, 1); cyc();
    cmp_table("R4");
  endtask

  task automatic t_restore();
    ret_req = 1; ret_tag = 9; cyc(); set_exp(5, 0, 0);
    cmp_table("R7");
    restore_req = 1; restore_id = 2; cyc();
    cmp_table("R5");
    branch_expect("R5", 2);
    branch_expect("R5", 3);
    ren(1, 0, 0, 0); #1; chk("R6", ckpt_stall, 1); idle();
  endtask

  task automatic t_free();
    free_req = 1; free_id = 1; cyc();
    ren(1, 0, 0, 0); #1; chk("R6", ckpt_stall, 1); idle();
    free_req = 1; free_id = 0; cyc();
    branch_expect("R6", 0);
  endtask

  task automatic t_restore_rename();
    restore_req = 1; restore_id = 3; ren(0, 1, 7, 7); cyc();
    cmp_table("R9");
    ren(1, 0, 0, 0); #1; chk("R9", ckpt_id, 3); chk("R9", ckpt_stall, 0); idle();
  endtask

  task automatic t_restore_retire();
    ren(0, 1, 6, 15); cyc();
    restore_req = 1; restore_id = 2; ret_req = 1; ret_tag = 12; cyc();
    set_exp(4, 0, 0);
    cmp_table("R10");
  endtask

  task automatic t_rename_retire();
    ren(0, 1, 3, 5); ret_req = 1; ret_tag = 5; cyc();
    cmp_table("R11");
  endtask

  task automatic t_flush();
    branch_expect("R8", 2);
    flush_all = 1; restore_req = 1; restore_id = 1; ren(0, 1, 6, 2); cyc();
    for (int r = 0; r < NA; r++) set_exp(r, 0, 0);
    cmp_table("R8");
    for (int k = 0; k < NC; k++) branch_expect("R8", k);
    ren(1, 0, 0, 0); #1; chk("R8", ckpt_stall, 1); idle();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rename_basic();
    t_checkpoints();
    t_restore();
    t_free();
    t_restore_rename();
    t_restore_retire();
    t_rename_retire();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule